// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by reading two levels of translation entries from memory. The first level, the directory, sits at a 4 KiB-aligned base taken from a configuration input. A directory entry either points at a second-level table or, when large pages are enabled, maps a 4 MiB region directly. Every entry carries present, writable and user-access bits, and each level is checked against the access type and privilege of the request.

A request gives the linear address, a write flag and a user flag. It is answered by a one-cycle response that carries the physical address or a fault indication. The walker keeps the accessed and dirty flags of the entries up to date in memory. These flags are sticky: they are only set, and a flag that is already set causes no extra write. On a fault the walker stores the linear address in a fault-address register and pulses a page-fault output. When translation is disabled, the address passes through without any memory traffic. Memory is reached through one word-wide port: a request is held until an acknowledge comes back, and read data is valid with the acknowledge.

Top module: `pgwalk_top`

## Requirements
- R1: With `cfg_xlate_en` low, an accepted request is answered on the next cycle with `resp_paddr` equal to the linear address, no fault, and no memory access.
- R2: For a 4 KiB mapping the directory entry is read from `{cfg_dir_base, laddr[31:22], 2'b00}`. The table entry is read from `{dir_entry[31:12], laddr[21:12], 2'b00}`. The result is `{table_entry[31:12], laddr[11:0]}`.
- R3: An entry whose bit 0 (present) is clear, at either level, ends the walk with `resp_fault` and `page_fault` high and `fault_addr` set to the linear address. The faulting entry is not written.
- R4: A write to a mapping in which bit 1 (writable) is clear at either level faults, whatever the privilege of the request.
- R5: A user access (`req_user` high) faults when bit 2 (user) is clear at either level. A supervisor access ignores bit 2.
- R6: Each entry that passes its checks has bit 5 (accessed) set in memory. The walker never clears it.
- R7: On a write, bit 6 (dirty) is set in the final entry only. A read leaves it unchanged, and a directory entry that points to a table never gets it.
- R8: A write-back is issued only when the entry value changes, so an entry whose flags are already set costs one read and no write.
- R9: With `cfg_large_en` high and directory bit 7 set, the result is `{dir_entry[31:22], laddr[21:0]}` and no table entry is read. With `cfg_large_en` low, bit 7 is ignored and the walk continues to the table.
- R10: `req_ready` is high only while idle. `resp_valid` is a one-cycle pulse. `mem_req`, `mem_addr` and `mem_we` stay unchanged until `mem_ack`.
- R11: `fault_addr` changes only when a fault is reported and otherwise keeps the last faulting address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_xlate_en | input | 1 | Translation enable; low gives pass-through |
| cfg_large_en | input | 1 | Enables 4 MiB mappings from directory bit 7 |
| cfg_dir_base | input | 20 | Frame number of the directory |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and accepting |
| req_laddr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user privilege |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | 32 | Physical address (zero on fault) |
| resp_fault | output | 1 | Response is a page fault |
| page_fault | output | 1 | Page-fault pulse, coincident with a faulting response |
| fault_addr | output | 32 | Last faulting linear address |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 32 | Memory read data |

## Verification
The assertions assume that the memory raises `mem_ack` only while `mem_req` is high, for a single cycle, and that the configuration inputs do not change while a walk is in progress. The bench memory model acknowledges one cycle after it sees a request and drops the acknowledge on the following cycle. Configuration changes are made only between requests, while `req_ready` is high and no response is pending. A new request is driven only after the previous response has been seen.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  // Entry flag positions (decoded by software that builds the tables)
  localparam int unsigned FL_PRESENT = 0;
  localparam int unsigned FL_WRITE   = 1;
  localparam int unsigned FL_USER    = 2;
  localparam int unsigned FL_ACCESS  = 5;
  localparam int unsigned FL_DIRTY   = 6;
  localparam int unsigned FL_LARGE   = 7;

  localparam int unsigned LEVELS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WB,
    ST_TBL_RD,
    ST_TBL_WB
  } walk_state_e;
endpackage

// File: rtl/pgwalk_entry_eval.sv
module pgwalk_entry_eval
  import pgwalk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] entry,
  input  logic          is_write,
  input  logic          is_user,
  input  logic          mark_dirty,
  output logic          fault,
  output logic [DW-1:0] upd,
  output logic          need_wb
);
  always_comb begin
    fault = !entry[FL_PRESENT]
          | (is_write & !entry[FL_WRITE])
          | (is_user  & !entry[FL_USER]);
    upd = entry;
    upd[FL_ACCESS] = 1'b1;
    if (mark_dirty) upd[FL_DIRTY] = 1'b1;
    need_wb = (upd != entry);
  end
endmodule

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-OFF_W-1:0] dir_base,
  input  logic [ADDR_W-1:0]       laddr,
  input  logic [ADDR_W-OFF_W-1:0] ent_frm,
  output logic [ADDR_W-1:0]       dir_ea,
  output logic [ADDR_W-1:0]       tbl_ea,
  output logic [ADDR_W-1:0]       pa_small,
  output logic [ADDR_W-1:0]       pa_large
);
  // Entries are 4 bytes, so an index shifted by two spans one frame.
  localparam int LG_W = OFF_W + IDX_W;
  localparam int FRM_W = ADDR_W - OFF_W;

  assign dir_ea   = {dir_base, laddr[ADDR_W-1 -: IDX_W], 2'b00};
  assign tbl_ea   = {ent_frm, laddr[LG_W-1:OFF_W], 2'b00};
  assign pa_small = {ent_frm, laddr[OFF_W-1:0]};
  assign pa_large = {ent_frm[FRM_W-1:IDX_W], laddr[LG_W-1:0]};
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_xlate_en,
  input  logic                    cfg_large_en,
  input  logic [ADDR_W-OFF_W-1:0] cfg_dir_base,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_laddr,
  input  logic                    req_write,
  input  logic                    req_user,
  output logic                    resp_valid,
  output logic [ADDR_W-1:0]       resp_paddr,
  output logic                    resp_fault,
  output logic                    page_fault,
  output logic [ADDR_W-1:0]       fault_addr,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [ADDR_W-1:0]       mem_wdata,
  input  logic                    mem_ack,
  input  logic [ADDR_W-1:0]       mem_rdata
);
  localparam int FRM_W = ADDR_W - OFF_W;

  walk_state_e       state;
  logic [ADDR_W-1:0] laddr_q, hold_q;
  logic              wr_q, usr_q, large_q;

  logic [ADDR_W-1:0] walk_la, dir_ea, tbl_ea, pa_small, pa_large;
  logic              lg_hit;
  logic [LEVELS-1:0] lv_dirty, lv_fault, lv_wb;
  logic [ADDR_W-1:0] lv_upd [LEVELS];

  assign req_ready = (state == ST_IDLE);
  assign walk_la   = (state == ST_IDLE) ? req_laddr : laddr_q;
  assign lg_hit    = cfg_large_en & mem_rdata[FL_LARGE];

  pgwalk_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .dir_base (cfg_dir_base),
    .laddr    (walk_la),
    .ent_frm  (mem_rdata[ADDR_W-1 -: FRM_W]),
    .dir_ea   (dir_ea),
    .tbl_ea   (tbl_ea),
    .pa_small (pa_small),
    .pa_large (pa_large)
  );

  // Level 0 is the directory (leaf only for a large mapping), level 1 the table.
  assign lv_dirty[0] = wr_q & lg_hit;
  assign lv_dirty[1] = wr_q;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    pgwalk_entry_eval #(.DW(ADDR_W)) u_eval (
      .entry      (mem_rdata),
      .is_write   (wr_q),
      .is_user    (usr_q),
      .mark_dirty (lv_dirty[g]),
      .fault      (lv_fault[g]),
      .upd        (lv_upd[g]),
      .need_wb    (lv_wb[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      laddr_q    <= '0;
      hold_q     <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      large_q    <= 1'b0;
      resp_valid <= 1'b0;
      resp_paddr <= '0;
      resp_fault <= 1'b0;
      page_fault <= 1'b0;
      fault_addr <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      resp_valid <= 1'b0;
      page_fault <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          laddr_q <= req_laddr;
          wr_q    <= req_write;
          usr_q   <= req_user;
          if (!cfg_xlate_en) begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b0;
            resp_paddr <= req_laddr;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= dir_ea;
            state    <= ST_DIR_RD;
          end
        end
        ST_DIR_RD: if (mem_ack) begin
          if (lv_fault[0]) begin
            mem_req    <= 1'b0;
            resp_valid <= 1'b1;
            resp_fault <= 1'b1;
            resp_paddr <= '0;
            page_fault <= 1'b1;
            fault_addr <= laddr_q;
            state      <= ST_IDLE;
          end else begin
            large_q <= lg_hit;
            hold_q  <= lg_hit ? pa_large : tbl_ea;
            if (lv_wb[0]) begin
              mem_we    <= 1'b1;
              mem_wdata <= lv_upd[0];
              state     <= ST_DIR_WB;
            end else if (lg_hit) begin
              mem_req    <= 1'b0;
              resp_valid <= 1'b1;
              resp_fault <= 1'b0;
              resp_paddr <= pa_large;
              state      <= ST_IDLE;
            end else begin
              mem_addr <= tbl_ea;
              state    <= ST_TBL_RD;
            end
          end
        end
        ST_DIR_WB: if (mem_ack) begin
          mem_we <= 1'b0;
          if (large_q) begin
            mem_req    <= 1'b0;
            resp_valid <= 1'b1;
            resp_fault <= 1'b0;
            resp_paddr <= hold_q;
            state      <= ST_IDLE;
          end else begin
            mem_addr <= hold_q;
            state    <= ST_TBL_RD;
          end
        end
        ST_TBL_RD: if (mem_ack) begin
          if (lv_fault[1]) begin
            mem_req    <= 1'b0;
            resp_valid <= 1'b1;
            resp_fault <= 1'b1;
            resp_paddr <= '0;
            page_fault <= 1'b1;
            fault_addr <= laddr_q;
            state      <= ST_IDLE;
          end else if (lv_wb[1]) begin
            hold_q    <= pa_small;
            mem_we    <= 1'b1;
            mem_wdata <= lv_upd[1];
            state     <= ST_TBL_WB;
          end else begin
            mem_req    <= 1'b0;
            resp_valid <= 1'b1;
            resp_fault <= 1'b0;
            resp_paddr <= pa_small;
            state      <= ST_IDLE;
          end
        end
        ST_TBL_WB: if (mem_ack) begin
          mem_req    <= 1'b0;
          mem_we     <= 1'b0;
          resp_valid <= 1'b1;
          resp_fault <= 1'b0;
          resp_paddr <= hold_q;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgwalk_checker.sv
module pgwalk_checker
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cfg_xlate_en,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [ADDR_W-1:0]       req_laddr,
  input logic                    resp_valid,
  input logic [ADDR_W-1:0]       resp_paddr,
  input logic                    resp_fault,
  input logic                    page_fault,
  input logic [ADDR_W-1:0]       fault_addr,
  input logic                    mem_req,
  input logic                    mem_we,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic [ADDR_W-1:0]       mem_wdata,
  input logic                    mem_ack
);
  logic [ADDR_W-1:0] acc_la;

  always_ff @(posedge clk) begin
    if (rst) acc_la <= '0;
    else if (req_valid && req_ready) acc_la <= req_laddr;
  end

  assert_passthru_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !cfg_xlate_en) |=>
      (resp_valid && !resp_fault && resp_paddr == $past(req_laddr) && !mem_req));

  assert_fault_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> (page_fault && fault_addr == acc_la));

  assert_wb_accessed_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[FL_ACCESS]);

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  assert_fault_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(fault_addr) |-> page_fault);
endmodule

bind pgwalk_top pgwalk_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_xlate_en (cfg_xlate_en),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_laddr    (req_laddr),
  .resp_valid   (resp_valid),
  .resp_paddr   (resp_paddr),
  .resp_fault   (resp_fault),
  .page_fault   (page_fault),
  .fault_addr   (fault_addr),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_ack      (mem_ack)
);

// File: tb/pgwalk_top_tb.sv
`timescale 1ns/1ps
module pgwalk_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_xlate_en = 1'b0, cfg_large_en = 1'b0;
  logic [19:0] cfg_dir_base = 20'h00001;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_laddr = '0;
  logic        req_ready, resp_valid, resp_fault, page_fault;
  logic [31:0] resp_paddr, fault_addr;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] mem [4096];

  always #2.5 clk = ~clk;

  pgwalk_top u_dut (
    .clk(clk), .rst(rst), .cfg_xlate_en(cfg_xlate_en), .cfg_large_en(cfg_large_en),
    .cfg_dir_base(cfg_dir_base), .req_valid(req_valid), .req_ready(req_ready),
    .req_laddr(req_laddr), .req_write(req_write), .req_user(req_user),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
    .page_fault(page_fault), .fault_addr(fault_addr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // Memory model: acknowledge one cycle after a request, then drop.
  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[13:2]] = mem_wdata;
        wr_cnt = wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[13:2]];
        rd_cnt = rd_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[13:2]];
  endfunction

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    mem[a[13:2]] = d;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [31:0] r_pa;
  logic        r_flt;

  task automatic walk(input logic [31:0] la, input bit w, input bit u);
    int guard = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    req_laddr = la; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    r_pa = resp_paddr;
    r_flt = resp_fault;
    chk(resp_valid, "R10 response arrives", {31'd0, resp_valid}, 32'd1);
    chk(page_fault == resp_fault, "R3 page_fault with fault response", {31'd0, page_fault}, {31'd0, resp_fault});
    @(negedge clk);
    chk(!resp_valid, "R10 response is one pulse", {31'd0, resp_valid}, 32'd0);
  endtask

  task automatic t_reset();
    chk(req_ready, "R10 ready after reset", {31'd0, req_ready}, 32'd1);
    chk(!resp_valid && !mem_req, "R10 quiet after reset", {30'd0, resp_valid, mem_req}, 32'd0);
    chk(fault_addr == 32'd0, "R11 fault_addr reset", fault_addr, 32'd0);
  endtask

  task automatic t_passthru();
    cfg_xlate_en = 1'b0;
    walk(32'hDEAD_BEEF, 1'b1, 1'b1);
    chk(!r_flt && r_pa == 32'hDEAD_BEEF, "R1 pass-through address", r_pa, 32'hDEAD_BEEF);
    chk(rd_cnt + wr_cnt == 0, "R1 no memory access", rd_cnt + wr_cnt, 0);
    cfg_xlate_en = 1'b1;
  endtask

  task automatic t_small_read();
    walk(32'h0040_5123, 1'b0, 1'b1);
    chk(!r_flt && r_pa == 32'h000A_B123, "R2 4K translation", r_pa, 32'h000A_B123);
    chk(rd_cnt == 2 && wr_cnt == 2, "R6 two reads two write-backs", rd_cnt * 16 + wr_cnt, 32'h22);
    chk(rd(32'h1004) == 32'h0000_2027, "R6 directory accessed", rd(32'h1004), 32'h0000_2027);
    chk(rd(32'h2014) == 32'h000A_B027, "R7 read leaves dirty clear", rd(32'h2014), 32'h000A_B027);
  endtask

  task automatic t_no_rewrite();
    walk(32'h0040_5FFF, 1'b0, 1'b0);
    chk(!r_flt && r_pa == 32'h000A_BFFF, "R2 offset at page top", r_pa, 32'h000A_BFFF);
    chk(rd_cnt == 2 && wr_cnt == 0, "R8 no write-back when unchanged", rd_cnt * 16 + wr_cnt, 32'h20);
  endtask

  task automatic t_dirty();
    walk(32'h0040_5004, 1'b1, 1'b0);
    chk(!r_flt && r_pa == 32'h000A_B004, "R7 write translation", r_pa, 32'h000A_B004);
    chk(wr_cnt == 1, "R8 only leaf written", wr_cnt, 1);
    chk(rd(32'h2014) == 32'h000A_B067, "R7 leaf dirty set", rd(32'h2014), 32'h000A_B067);
    chk(rd(32'h1004) == 32'h0000_2027, "R7 directory not dirty", rd(32'h1004), 32'h0000_2027);
  endtask

  task automatic t_not_present();
    walk(32'h0040_6000, 1'b0, 1'b0);
    chk(r_flt && r_pa == 32'd0, "R3 table not present", {31'd0, r_flt}, 32'd1);
    chk(fault_addr == 32'h0040_6000, "R3 fault address", fault_addr, 32'h0040_6000);
    chk(wr_cnt == 0 && rd(32'h2018) == 32'd0, "R3 faulting entry untouched", rd(32'h2018), 32'd0);
    walk(32'h0080_0ABC, 1'b0, 1'b0);
    chk(r_flt && rd_cnt == 1, "R3 directory not present", rd_cnt, 1);
    chk(fault_addr == 32'h0080_0ABC, "R3 fault address directory", fault_addr, 32'h0080_0ABC);
  endtask

  task automatic t_read_only();
    walk(32'h00C0_0010, 1'b1, 1'b0);
    chk(r_flt, "R4 write to read-only page", {31'd0, r_flt}, 32'd1);
    chk(rd(32'h3000) == 32'h0005_5005, "R4 read-only entry untouched", rd(32'h3000), 32'h0005_5005);
    walk(32'h00C0_0010, 1'b0, 1'b1);
    chk(!r_flt && r_pa == 32'h0005_5010, "R4 read of read-only page", r_pa, 32'h0005_5010);
  endtask

  task automatic t_user();
    walk(32'h0100_0010, 1'b0, 1'b1);
    chk(r_flt && rd_cnt == 1, "R5 user blocked at directory", {31'd0, r_flt}, 32'd1);
    chk(rd(32'h1010) == 32'h0000_3003, "R5 blocked entry untouched", rd(32'h1010), 32'h0000_3003);
    walk(32'h0100_0010, 1'b0, 1'b0);
    chk(!r_flt && r_pa == 32'h0005_5010, "R5 supervisor allowed", r_pa, 32'h0005_5010);
    chk(rd(32'h1010) == 32'h0000_3023, "R6 directory accessed", rd(32'h1010), 32'h0000_3023);
  endtask

  task automatic t_large();
    cfg_large_en = 1'b1;
    walk(32'h0140_1234, 1'b1, 1'b1);
    chk(!r_flt && r_pa == 32'h1240_1234, "R9 large page address", r_pa, 32'h1240_1234);
    chk(rd_cnt == 1 && wr_cnt == 1, "R9 no table read", rd_cnt * 16 + wr_cnt, 32'h11);
    chk(rd(32'h1014) == 32'h1240_00E7, "R7 large entry dirty", rd(32'h1014), 32'h1240_00E7);
    cfg_large_en = 1'b0;
    walk(32'h0180_5123, 1'b0, 1'b0);
    chk(!r_flt && r_pa == 32'h000A_B123, "R9 large bit ignored when off", r_pa, 32'h000A_B123);
    chk(rd_cnt == 2 && wr_cnt == 1, "R9 table still read", rd_cnt * 16 + wr_cnt, 32'h21);
  endtask

  task automatic t_fault_hold();
    chk(fault_addr == 32'h0100_0010, "R11 fault_addr held", fault_addr, 32'h0100_0010);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    wr(32'h1004, 32'h0000_2007);
    wr(32'h2014, 32'h000A_B007);
    wr(32'h100C, 32'h0000_3007);
    wr(32'h3000, 32'h0005_5005);
    wr(32'h1010, 32'h0000_3003);
    wr(32'h1014, 32'h1240_0087);
    wr(32'h1018, 32'h0000_2087);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_passthru();
    t_small_read();
    t_no_rewrite();
    t_dirty();
    t_not_present();
    t_read_only();
    t_user();
    t_large();
    t_fault_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule